// File: doc/BRIEF.md
# Byte-Controlled Latched Bidirectional Transceiver

This block moves data between two 16-bit buses, called side A and side B. Each direction has its own bank of byte-wide storage. The A-to-B bank takes data from side A and presents it on side B. The B-to-A bank does the same in the other direction.

Each byte lane of each direction has three active-low controls: a chip-enable, a capture-enable and a drive-enable. The lanes can be tied together for full 16-bit operation, or run one at a time. Data passes through without inversion.

The tri-state pads sit outside the block. For that reason each side has a data output and an active-high drive-enable for each byte. The surrounding logic resolves the physical bus.

Storage is modelled as a register on the system clock. A lane is "transparent" when its chip-enable and capture-enable are both low at a rising edge. In that case the lane loads the input byte at that edge. Otherwise it keeps its value.

Top module: `byte_latch_xcvr`

## Requirements
- R1: After synchronous reset (`rst` high at a rising edge), every stored byte is 0x00 and all four drive-enables (`a_oe`, `b_oe`) are low.
- R2: When `ceab_n[k]` and `leab_n[k]` are both low at a rising edge, lane k of the A-to-B store takes `a_in[8k+7:8k]`. The value appears unchanged (not inverted) on `b_out[8k+7:8k]` after that edge. While both stay low, the store follows `a_in` edge by edge.
- R3: While `leab_n[k]` is high, the lane k A-to-B store keeps its value, whatever `a_in` does.
- R4: While `ceab_n[k]` is high, the lane k A-to-B store keeps its value, even with `leab_n[k]` low.
- R5: `b_oe[k]` is high exactly when `ceab_n[k]` and `oeab_n[k]` are both low. It follows these inputs in the same cycle.
- R6: `oeab_n` and `oeba_n` have no effect on stored data. `b_out` and `a_out` always show the stored bytes, whether or not they are driven.
- R7: Lane 0 (bits 7:0) and lane 1 (bits 15:8) are independent. Controls of one lane never change the other lane's store or drive-enable.
- R8: The B-to-A direction follows R2–R5 using `ceba_n`, `leba_n`, `oeba_n`, with `b_in` as source, `a_out` as stored data and `a_oe` as drive-enable.
- R9: No byte lane may have `a_oe[k]` and `b_oe[k]` high together. The block does not prevent this; it flags it as a usage violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Side A data in (source of A-to-B) |
| b_in | input | 16 | Side B data in (source of B-to-A) |
| ceab_n | input | 2 | A-to-B chip-enable per lane, active low |
| leab_n | input | 2 | A-to-B capture-enable per lane, active low |
| oeab_n | input | 2 | A-to-B drive-enable request per lane, active low |
| ceba_n | input | 2 | B-to-A chip-enable per lane, active low |
| leba_n | input | 2 | B-to-A capture-enable per lane, active low |
| oeba_n | input | 2 | B-to-A drive-enable request per lane, active low |
| a_out | output | 16 | B-to-A stored data toward side A |
| a_oe | output | 2 | Side A drive-enable per lane, active high |
| b_out | output | 16 | A-to-B stored data toward side B |
| b_oe | output | 2 | Side B drive-enable per lane, active high |

## Verification
The hardest case to reach is a lane holding its data while other inputs keep moving. The stored byte must survive changes on the source bus, toggles of the drive-enable request, and captures in the neighbouring lane.

Directed phases cover this. One phase loads a known byte, raises the capture-enable (or the chip-enable), and then changes the source bus and the drive-enable request. Another phase captures into only one lane.

A phase of random control and data patterns follows. It is shaped so that the two directions never drive the same lane together. Each cycle is compared against a behavioural reference model.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    parameter int LANES  = 2;
    parameter int LANE_W = 8;
    localparam int BUS_W = LANES * LANE_W;

    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } lane_ctrl_t;

    function automatic logic capture_ok(input lane_ctrl_t c);
        return !c.ce_n && !c.le_n;
    endfunction

    function automatic logic drive_ok(input lane_ctrl_t c);
        return !c.ce_n && !c.oe_n;
    endfunction
endpackage

// File: rtl/xcvr_lane_latch.sv
module xcvr_lane_latch
    import xcvr_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   d,
    input  lane_ctrl_t     ctrl,
    output logic [W-1:0]   q,
    output logic           drive
);
    logic cap;
    assign cap   = capture_ok(ctrl);
    assign drive = drive_ok(ctrl);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (cap)
            q <= d;
    end

    // R2: a capture edge loads the input byte
    assert_capture_loads_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.ce_n && !ctrl.le_n) |=> (q == $past(d)));

    // R3: capture-enable high keeps the stored byte
    assert_hold_le_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl.le_n |=> $stable(q));

    // R4: chip-enable high keeps the stored byte
    assert_hold_ce_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl.ce_n |=> $stable(q));
endmodule

// File: rtl/xcvr_dir_bank.sv
module xcvr_dir_bank
    import xcvr_pkg::*;
#(
    parameter int NL = LANES,
    parameter int LW = LANE_W,
    localparam int BW = NL * LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] src,
    input  logic [NL-1:0] ce_n,
    input  logic [NL-1:0] le_n,
    input  logic [NL-1:0] oe_n,
    output logic [BW-1:0] held,
    output logic [NL-1:0] drv
);
    for (genvar k = 0; k < NL; k++) begin : g_lane
        lane_ctrl_t c;
        assign c.ce_n = ce_n[k];
        assign c.le_n = le_n[k];
        assign c.oe_n = oe_n[k];

        xcvr_lane_latch #(.W(LW)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .d     (src[k*LW +: LW]),
            .ctrl  (c),
            .q     (held[k*LW +: LW]),
            .drive (drv[k])
        );
    end
endmodule

// File: rtl/byte_latch_xcvr.sv
module byte_latch_xcvr
    import xcvr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] a_in,
    input  logic [BUS_W-1:0] b_in,
    input  logic [LANES-1:0] ceab_n,
    input  logic [LANES-1:0] leab_n,
    input  logic [LANES-1:0] oeab_n,
    input  logic [LANES-1:0] ceba_n,
    input  logic [LANES-1:0] leba_n,
    input  logic [LANES-1:0] oeba_n,
    output logic [BUS_W-1:0] a_out,
    output logic [LANES-1:0] a_oe,
    output logic [BUS_W-1:0] b_out,
    output logic [LANES-1:0] b_oe
);
    xcvr_dir_bank #(.NL(LANES), .LW(LANE_W)) u_ab (
        .clk  (clk),
        .rst  (rst),
        .src  (a_in),
        .ce_n (ceab_n),
        .le_n (leab_n),
        .oe_n (oeab_n),
        .held (b_out),
        .drv  (b_oe)
    );

    xcvr_dir_bank #(.NL(LANES), .LW(LANE_W)) u_ba (
        .clk  (clk),
        .rst  (rst),
        .src  (b_in),
        .ce_n (ceba_n),
        .le_n (leba_n),
        .oe_n (oeba_n),
        .held (a_out),
        .drv  (a_oe)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        // R9: both sides driving one lane is a usage violation
        assert_no_contention_R9: assert property (@(posedge clk) disable iff (rst)
            !(a_oe[k] && b_oe[k]));

        // R5: a disabled chip keeps the side B lane undriven
        assert_b_quiet_R5: assert property (@(posedge clk) disable iff (rst)
            (ceab_n[k] || oeab_n[k]) |-> !b_oe[k]);

        // R8: same rule for side A
        assert_a_quiet_R8: assert property (@(posedge clk) disable iff (rst)
            (ceba_n[k] || oeba_n[k]) |-> !a_oe[k]);
    end
endmodule

// File: tb/byte_latch_xcvr_test.sv
module byte_latch_xcvr_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_in = '0, b_in = '0;
    logic [1:0]  ceab_n = 2'b11, leab_n = 2'b11, oeab_n = 2'b11;
    logic [1:0]  ceba_n = 2'b11, leba_n = 2'b11, oeba_n = 2'b11;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_oe, b_oe;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";
    bit done = 0;

    // reference stores
    logic [7:0] m_ab [2];
    logic [7:0] m_ba [2];

    always #10 clk = ~clk;

    byte_latch_xcvr uut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ceab_n(ceab_n), .leab_n(leab_n), .oeab_n(oeab_n),
        .ceba_n(ceba_n), .leba_n(leba_n), .oeba_n(oeba_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                m_ab[k] <= 8'h00;
                m_ba[k] <= 8'h00;
            end else begin
                if (ceab_n[k] == 1'b0 && leab_n[k] == 1'b0) m_ab[k] <= a_in[k*8 +: 8];
                if (ceba_n[k] == 1'b0 && leba_n[k] == 1'b0) m_ba[k] <= b_in[k*8 +: 8];
            end
        end
    end

    task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [1:0] eb, ea;
        for (int k = 0; k < 2; k++) begin
            eb[k] = !ceab_n[k] && !oeab_n[k];
            ea[k] = !ceba_n[k] && !oeba_n[k];
        end
        chk({tag, " b_out"}, b_out, {m_ab[1], m_ab[0]});
        chk({tag, " a_out"}, a_out, {m_ba[1], m_ba[0]});
        chk({tag, " b_oe R5"}, {14'd0, b_oe}, {14'd0, eb});
        chk({tag, " a_oe R8"}, {14'd0, a_oe}, {14'd0, ea});
        chk("R9 contention", {14'd0, a_oe & b_oe}, 16'd0);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        tag = "R1";
        tick();
        chk("R1 b_out zero", b_out, 16'h0000);
        chk("R1 oe low", {12'd0, a_oe, b_oe}, 16'd0);

        // R2: transparent capture on lane 0
        tag = "R2";
        ceab_n = 2'b10; leab_n = 2'b10; oeab_n = 2'b10; a_in = 16'h335A;
        tick();
        chk("R2 lane0 captured", {8'h00, b_out[7:0]}, 16'h005A);
        a_in = 16'h44C3;
        tick();
        chk("R2 follows", {8'h00, b_out[7:0]}, 16'h00C3);

        // R3: capture-enable high holds
        tag = "R3";
        leab_n = 2'b11; a_in = 16'h1111;
        tick();
        a_in = 16'hFFFF;
        tick();
        chk("R3 held", {8'h00, b_out[7:0]}, 16'h00C3);

        // R4: chip-enable high holds even with capture-enable low
        tag = "R4";
        ceab_n = 2'b11; leab_n = 2'b00; a_in = 16'h7E7E;
        tick();
        chk("R4 held", {8'h00, b_out[7:0]}, 16'h00C3);
        chk("R4 undriven", {14'd0, b_oe}, 16'd0);

        // R6: toggling drive request does not touch data
        tag = "R6";
        ceab_n = 2'b10; leab_n = 2'b11;
        for (int i = 0; i < 4; i++) begin
            oeab_n = (i % 2 == 0) ? 2'b11 : 2'b10;
            a_in = 16'(i * 16'h1357);
            tick();
        end
        chk("R6 data kept", {8'h00, b_out[7:0]}, 16'h00C3);

        // R7: capture lane 1 only, lane 0 untouched
        tag = "R7";
        ceab_n = 2'b01; leab_n = 2'b01; oeab_n = 2'b11; a_in = 16'hA596;
        tick();
        chk("R7 lane split", b_out, 16'hA5C3);
        ceab_n = 2'b11; leab_n = 2'b11;

        // R8: B-to-A direction
        tag = "R8";
        ceba_n = 2'b00; leba_n = 2'b00; oeba_n = 2'b00; b_in = 16'hBEEF;
        tick();
        chk("R8 captured", a_out, 16'hBEEF);
        leba_n = 2'b11; b_in = 16'h0000;
        tick();
        chk("R8 held", a_out, 16'hBEEF);
        chk("R8 driven", {14'd0, a_oe}, 16'h0003);
        oeba_n = 2'b11;

        // random phase, no lane driven from both sides
        tag = "R7 random";
        for (int i = 0; i < 400; i++) begin
            a_in   = 16'($urandom);
            b_in   = 16'($urandom);
            ceab_n = 2'($urandom); leab_n = 2'($urandom); oeab_n = 2'($urandom);
            ceba_n = 2'($urandom); leba_n = 2'($urandom); oeba_n = 2'($urandom);
            for (int k = 0; k < 2; k++)
                if (!ceab_n[k] && !oeab_n[k]) oeba_n[k] = 1'b1;
            tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule